// File: doc/BRIEF.md
# Parameterized Synchronous Up/Down Counter

This block is a binary counter whose every state change happens on the rising edge of its clock. It has a synchronous clear, a synchronous set to a value fixed by a parameter, a synchronous parallel load, a direction input, a count enable and a clock enable that gates all synchronous activity. The width, the set value, an optional modulus and the direction are parameters. The direction can follow a port, or it can be fixed up or fixed down.

The controls resolve in a fixed priority: clock enable, then clear, then set, then load, then counting. The count enable gates only counting. With a modulus M, the counter steps 0, 1, ..., M-1 and then wraps in either direction. With no modulus (M = 0), it wraps at 2^WIDTH. A loaded value at or above M is kept unchanged, and the next up-count from it returns to zero.

Top module: `updn_counter`

## Requirements
- R1: While `rstN` is low at a rising edge, `count` becomes 0.
- R2: When `clkEn` is low, `count` holds whatever the other controls request.
- R3: With `clkEn` high and `sClr` high, `count` becomes 0 at the next edge, even if `sSet` or `sLoad` is also high.
- R4: With `clkEn` high, `sClr` low and `sSet` high, `count` becomes `SET_VALUE` (default all ones), even if `sLoad` is high.
- R5: With `clkEn` high, `sClr` and `sSet` low and `sLoad` high, `count` takes `loadData`, whatever the value of `cntEn`.
- R6: With `clkEn` high, no clear, set or load, and `cntEn` low, `count` holds.
- R7: With `DIR_MODE` = DIR_PORT, `dirUp` = 1 makes the counter count up by one per enabled edge, and `dirUp` = 0 makes it count down by one.
- R8: With `DIR_MODE` = DIR_UP or DIR_DOWN, the counter counts in that fixed direction and ignores `dirUp`.
- R9: With `MODULUS` = M > 0, counting up from M-1 gives 0, and counting down from 0 gives M-1.
- R10: With `MODULUS` = 0, counting up from all ones gives 0, and counting down from 0 gives all ones.
- R11: A loaded value at or above M stays unchanged until the next action. An up-count from it gives 0, and a down-count from it gives the value minus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Synchronous active-low reset to zero |
| clkEn | input | 1 | Enables all synchronous actions |
| sClr | input | 1 | Synchronous clear |
| sSet | input | 1 | Synchronous set to SET_VALUE |
| sLoad | input | 1 | Synchronous parallel load |
| cntEn | input | 1 | Enables counting only |
| dirUp | input | 1 | 1 = up, 0 = down; used only when DIR_MODE is DIR_PORT |
| loadData | input | WIDTH | Parallel load value |
| count | output | WIDTH | Registered count |

## Verification
The assertions assume that the control inputs are stable at each rising edge. They also assume that `MODULUS` is either 0 or at most 2^WIDTH, so that M-1 fits in the counter. The stimulus changes inputs only on falling edges. It keeps the modulus within this range for all three counter configurations (widths 1, 4 and 8). It still loads values at or above the modulus, because R11 defines that case.

// File: rtl/updn_counter_pkg.sv
package updn_counter_pkg;
  typedef enum logic [1:0] {
    DIR_PORT = 2'd0,
    DIR_UP   = 2'd1,
    DIR_DOWN = 2'd2
  } dirMode_e;

  typedef struct packed {
    logic doClear;
    logic doSet;
    logic doLoad;
    logic doStep;
    logic stepUp;
  } ctrStrobe_t;
endpackage

// File: rtl/updn_counter_ctrl.sv
module updn_counter_ctrl
  import updn_counter_pkg::*;
#(
  parameter dirMode_e DIR_MODE = DIR_PORT
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       clkEn,
  input  logic       sClr,
  input  logic       sSet,
  input  logic       sLoad,
  input  logic       cntEn,
  input  logic       dirUp,
  output ctrStrobe_t strobe
);
  logic stepDir;

  generate
    if (DIR_MODE == DIR_PORT) begin : g_dirPort
      assign stepDir = dirUp;
    end else if (DIR_MODE == DIR_UP) begin : g_dirUp
      assign stepDir = 1'b1;
    end else begin : g_dirDown
      assign stepDir = 1'b0;
    end
  endgenerate

  always_comb begin
    strobe = '0;
    strobe.stepUp = stepDir;
    if (clkEn) begin
      if (sClr)        strobe.doClear = 1'b1;
      else if (sSet)   strobe.doSet   = 1'b1;
      else if (sLoad)  strobe.doLoad  = 1'b1;
      else if (cntEn)  strobe.doStep  = 1'b1;
    end
  end

  // R2: a disabled clock issues no strobe at all
  assert_gate_all_R2: assert property (@(posedge clk) disable iff (!rstN)
    !clkEn |-> !(strobe.doClear || strobe.doSet || strobe.doLoad || strobe.doStep));

  // R3: clear dominates every other request
  assert_clear_wins_R3: assert property (@(posedge clk) disable iff (!rstN)
    (clkEn && sClr) |-> (strobe.doClear && !strobe.doSet && !strobe.doLoad && !strobe.doStep));

  // R5: load is not blocked by a low count enable
  assert_load_ignores_cnten_R5: assert property (@(posedge clk) disable iff (!rstN)
    (clkEn && !sClr && !sSet && sLoad && !cntEn) |-> strobe.doLoad);

  assert_onehot_strobes_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.doClear, strobe.doSet, strobe.doLoad, strobe.doStep}));
endmodule

// File: rtl/updn_counter_dp.sv
module updn_counter_dp
  import updn_counter_pkg::*;
#(
  parameter int unsigned       WIDTH     = 4,
  parameter logic [WIDTH-1:0]  SET_VALUE = '1,
  parameter int unsigned       MODULUS   = 0
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrStrobe_t       strobe,
  input  logic [WIDTH-1:0] loadData,
  output logic [WIDTH-1:0] count
);
  localparam logic [WIDTH-1:0] LAST_VAL =
    (MODULUS == 0) ? {WIDTH{1'b1}} : WIDTH'(MODULUS - 1);

  logic [WIDTH-1:0] cntQ, cntD, upVal, downVal;

  generate
    if (MODULUS == 0) begin : g_natural
      assign upVal = cntQ + 1'b1;
    end else begin : g_modulo
      assign upVal = (cntQ >= LAST_VAL) ? '0 : cntQ + 1'b1;
    end
  endgenerate

  assign downVal = (cntQ == '0) ? LAST_VAL : cntQ - 1'b1;

  always_comb begin
    cntD = cntQ;
    if (strobe.doClear)      cntD = '0;
    else if (strobe.doSet)   cntD = SET_VALUE;
    else if (strobe.doLoad)  cntD = loadData;
    else if (strobe.doStep)  cntD = strobe.stepUp ? upVal : downVal;
  end

  always_ff @(posedge clk) begin
    if (!rstN) cntQ <= '0;
    else       cntQ <= cntD;
  end

  assign count = cntQ;

  assert_clear_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doClear |=> (count == '0));

  assert_set_value_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doSet |=> (count == SET_VALUE));

  assert_load_value_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doLoad |=> (count == $past(loadData)));

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.doClear || strobe.doSet || strobe.doLoad || strobe.doStep) |=> $stable(count));

  assert_down_wrap_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.doStep && !strobe.stepUp && count == '0) |=> (count == LAST_VAL));

  generate
    if (MODULUS != 0) begin : g_wrapChk
      assert_up_wrap_R11: assert property (@(posedge clk) disable iff (!rstN)
        (strobe.doStep && strobe.stepUp && count >= LAST_VAL) |=> (count == '0));
    end else begin : g_natChk
      assert_up_wrap_R10: assert property (@(posedge clk) disable iff (!rstN)
        (strobe.doStep && strobe.stepUp && count == LAST_VAL) |=> (count == '0));
    end
  endgenerate
endmodule

// File: rtl/updn_counter.sv
module updn_counter
  import updn_counter_pkg::*;
#(
  parameter int unsigned      WIDTH     = 4,
  parameter logic [WIDTH-1:0] SET_VALUE = '1,
  parameter int unsigned      MODULUS   = 0,
  parameter dirMode_e         DIR_MODE  = DIR_PORT
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clkEn,
  input  logic             sClr,
  input  logic             sSet,
  input  logic             sLoad,
  input  logic             cntEn,
  input  logic             dirUp,
  input  logic [WIDTH-1:0] loadData,
  output logic [WIDTH-1:0] count
);
  ctrStrobe_t strobe;

  updn_counter_ctrl #(.DIR_MODE(DIR_MODE)) ctrl_i (
    .clk(clk), .rstN(rstN), .clkEn(clkEn), .sClr(sClr), .sSet(sSet),
    .sLoad(sLoad), .cntEn(cntEn), .dirUp(dirUp), .strobe(strobe)
  );

  updn_counter_dp #(.WIDTH(WIDTH), .SET_VALUE(SET_VALUE), .MODULUS(MODULUS)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .loadData(loadData), .count(count)
  );
endmodule

// File: tb/updn_counter_tb_top.sv
module updn_counter_tb_top;
  import updn_counter_pkg::*;

  logic clk = 1'b0;
  logic rstN, clkEn, sClr, sSet, sLoad, cntEn, dirUp;
  logic [7:0] loadData;
  logic [3:0] cntA;
  logic [0:0] cntB;
  logic [7:0] cntC;
  int unsigned refA, refB, refC;
  int nTests = 0;
  int nFail = 0;
  bit finished = 0;
  string tag = "R1";

  always #10 clk = ~clk;

  // A: width 4, modulus 10, port direction, set all ones
  updn_counter #(.WIDTH(4), .MODULUS(10), .DIR_MODE(DIR_PORT)) dut_i (
    .clk(clk), .rstN(rstN), .clkEn(clkEn), .sClr(sClr), .sSet(sSet), .sLoad(sLoad),
    .cntEn(cntEn), .dirUp(dirUp), .loadData(loadData[3:0]), .count(cntA));
  // B: width 1, no modulus, fixed up
  updn_counter #(.WIDTH(1), .MODULUS(0), .DIR_MODE(DIR_UP)) dutW1_i (
    .clk(clk), .rstN(rstN), .clkEn(clkEn), .sClr(sClr), .sSet(sSet), .sLoad(sLoad),
    .cntEn(cntEn), .dirUp(dirUp), .loadData(loadData[0:0]), .count(cntB));
  // C: width 8, no modulus, fixed down, set value A5
  updn_counter #(.WIDTH(8), .SET_VALUE(8'hA5), .MODULUS(0), .DIR_MODE(DIR_DOWN)) dutW8_i (
    .clk(clk), .rstN(rstN), .clkEn(clkEn), .sClr(sClr), .sSet(sSet), .sLoad(sLoad),
    .cntEn(cntEn), .dirUp(dirUp), .loadData(loadData), .count(cntC));

  function automatic int unsigned refNext(int unsigned cur, int w, int unsigned m,
                                          int unsigned setv, int dirSel);
    int unsigned lim = (m == 0) ? (32'd1 << w) : m;
    int unsigned d = loadData & ((32'd1 << w) - 1);
    bit up = (dirSel == 0) ? dirUp : (dirSel == 1);
    if (!clkEn) return cur;
    if (sClr) return 0;
    if (sSet) return setv;
    if (sLoad) return d;
    if (!cntEn) return cur;
    if (up) return (cur + 1 >= lim) ? 0 : cur + 1;
    return (cur == 0) ? lim - 1 : cur - 1;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      refA = 0; refB = 0; refC = 0;
    end else begin
      refA = refNext(refA, 4, 10, 15, 0);
      refB = refNext(refB, 1, 0, 1, 1);
      refC = refNext(refC, 8, 0, 8'hA5, 2);
    end
  end

  task automatic check(string name, int unsigned act, int unsigned exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s counter %s: actual %0d expected %0d", tag, name, act, exp);
    end
  endtask

  task automatic compareAll();
    check("A", cntA, refA);
    check("B", cntB, refB);
    check("C", cntC, refC);
  endtask

  task automatic step(string t, bit ce, bit clr, bit st, bit ld, bit cen, bit up,
                      logic [7:0] d, int n);
    for (int i = 0; i < n; i++) begin
      tag = t; clkEn = ce; sClr = clr; sSet = st; sLoad = ld; cntEn = cen; dirUp = up;
      loadData = d;
      @(posedge clk);
      @(negedge clk);
      compareAll();
    end
  endtask

  initial begin
    rstN = 0; clkEn = 1; sClr = 0; sSet = 0; sLoad = 0; cntEn = 1; dirUp = 1;
    loadData = 8'h5A;
    repeat (3) @(negedge clk);
    tag = "R1";
    compareAll();
    rstN = 1;
    step("R7/R8/R9/R10 up", 1, 0, 0, 0, 1, 1, 8'h00, 12);
    step("R7/R8/R9/R10 down", 1, 0, 0, 0, 1, 0, 8'h00, 14);
    step("R6", 1, 0, 0, 0, 0, 1, 8'h33, 3);
    step("R2", 0, 1, 1, 1, 1, 1, 8'h77, 3);
    step("R4", 1, 0, 1, 1, 1, 0, 8'h12, 1);
    step("R2", 0, 0, 0, 0, 1, 1, 8'h00, 2);
    step("R3", 1, 1, 1, 1, 1, 1, 8'h77, 1);
    step("R5", 1, 0, 0, 1, 0, 1, 8'h0D, 1);
    step("R11 hold", 1, 0, 0, 0, 0, 1, 8'h00, 2);
    step("R11 up", 1, 0, 0, 0, 1, 1, 8'h00, 1);
    step("R5", 1, 0, 0, 1, 1, 0, 8'h0F, 1);
    step("R11 down", 1, 0, 0, 0, 1, 0, 8'h00, 2);
    step("R5", 1, 0, 0, 1, 0, 0, 8'h00, 1);
    step("R10", 1, 0, 0, 0, 1, 0, 8'h00, 2);
    step("R5", 1, 0, 0, 1, 0, 1, 8'h09, 1);
    step("R9", 1, 0, 0, 0, 1, 1, 8'h00, 1);
    for (int k = 0; k < 400; k++) begin
      logic [31:0] r = $urandom;
      step("mixed", r[0] | r[1], r[2] & r[3] & r[4], r[5] & r[6] & r[7], r[8] & r[9],
           r[10] | r[11], r[12], r[23:16], 1);
    end
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      nTests++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end
endmodule